// File: doc/BRIEF.md
# I2C Master Start and Address Sequencer

This block runs the opening phase of an I2C master transaction. Software asks for a Start. The sequencer waits until the bus is free, or, when it already owns the bus, until the current data byte has finished. It then asks a byte shifter to put a Start or repeated-Start condition on the wire. Once that condition is out, it enters master mode and raises a start-sent event.

From there, software clears each event by accessing the status and data registers in a fixed order, and each clearing access moves the sequencer forward:

- A data-register write that follows a status-1 read supplies an address byte, which goes out through the shifter.
- With 7-bit addressing, one byte completes the phase and raises address-sent.
- With 10-bit addressing, the first byte is a header. It raises its own header-sent event, and a second read-then-write pair supplies the low address byte.
- Address-sent is cleared by a status-1 read followed by a status-2 read. The sequencer then hands over to the data phase.
- A NACK on any address byte drops master mode, raises an acknowledge-failure flag and returns the sequencer to idle.

An event interrupt combines the pending events under an enable.

Top module: `i2c_addr_sequencer`

## Requirements
- R1: A start request produces a condition request only while `bus_busy` is low when the sequencer is idle; `flag_master` sets together with `flag_sb`.
- R2: A start request made in master mode (data phase) raises the condition request only after `byte_active` is low.
- R3: `flag_sb` sets on the cycle after `cond_done` is seen during a condition request.
- R4: `evt_irq` equals `evt_en` AND (`flag_sb` OR `flag_add10` OR `flag_addr`); at most one of these three is set at a time; all flags are 0 after reset.
- R5: In 7-bit mode (`addr10_mode`=0), a data write after a status-1 read sends exactly the written byte on `sh_byte`; an acknowledged `sh_done` sets `flag_addr` and leaves `flag_add10` at 0.
- R6: In 10-bit mode (`addr10_mode`=1), the first written byte is sent as a header and its acknowledgement sets `flag_add10`; a further status-1 read plus data write clears it and sends the second byte, whose acknowledgement sets `flag_addr`.
- R7: `flag_addr` stays set until a `sr2_rd` that follows a `sr1_rd` made while an event was pending; a lone `sr2_rd` leaves it set.
- R8: `flag_sb` clears on a data write that follows such a status-1 read; a data write with no preceding status-1 read changes no flag and sends no byte.
- R9: `sh_nack` together with `sh_done` on an address byte sets `flag_af`, clears `flag_master` and returns to idle with no byte or condition request; `flag_af` clears when the next Start sets `flag_sb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | One-cycle request for a Start |
| bus_busy | input | 1 | Bus held by another master |
| byte_active | input | 1 | Data-phase byte in progress |
| addr10_mode | input | 1 | 1 = 10-bit addressing |
| evt_en | input | 1 | Event interrupt enable |
| dr_wr | input | 1 | Data-register write strobe |
| dr_wdata | input | BYTE_W | Data-register write value |
| sr1_rd | input | 1 | Status register 1 read strobe |
| sr2_rd | input | 1 | Status register 2 read strobe |
| cond_req | output | 1 | Shifter: generate Start/repeated Start |
| cond_done | input | 1 | Shifter: condition finished |
| byte_req | output | 1 | Shifter: send `sh_byte` |
| sh_byte | output | BYTE_W | Byte to send |
| sh_done | input | 1 | Shifter: byte finished |
| sh_nack | input | 1 | Shifter: byte not acknowledged (valid with `sh_done`) |
| flag_sb | output | 1 | Start sent |
| flag_add10 | output | 1 | 10-bit header sent |
| flag_addr | output | 1 | Address sent |
| flag_master | output | 1 | Master mode |
| flag_af | output | 1 | Acknowledge failure |
| evt_irq | output | 1 | Event interrupt |

## Verification
All flags are registered. A flag therefore changes on the clock edge that samples its cause (`cond_done`, `sh_done`, or the clearing write or read) and is read one half-cycle later, at the falling edge. The condition and byte requests follow the state register. They rise one edge after the enabling input is seen, except that a start request first spends one edge in its pending latch. The checks for "no request yet" and "ignored access" therefore wait several cycles before reading the ports. Events are awaited with a bounded poll at falling edges. The shifter model compares each sent byte with the byte queued by the write task at the moment the request appears.

// File: rtl/i2cas_pkg.sv
// Shared types for the I2C start/address sequencer.
package i2cas_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_COND,
        ST_WAIT_SB,
        ST_SEND_HDR,
        ST_WAIT_HDR,
        ST_SEND_ADDR,
        ST_WAIT_ADDR,
        ST_DATA
    } phase_t;
endpackage

// File: rtl/i2cas_access_tracker.sv
// Tracks the software access ordering: a status-1 read made while an
// event is pending arms the next data write or status-2 read.
// Assumes strobes are one-cycle pulses, at most one access per cycle.
module i2cas_access_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic sr1_rd,
    input  logic sr2_rd,
    input  logic dr_wr,
    input  logic any_pending,
    output logic wr_ok,
    output logic rd2_ok
);
    logic seen;

    // Arm on a qualifying status-1 read, disarm on the follow-up access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen <= 1'b0;
        else if (dr_wr || sr2_rd)
            seen <= 1'b0;
        else if (sr1_rd && any_pending)
            seen <= 1'b1;
    end

    assign wr_ok  = dr_wr && seen;
    assign rd2_ok = sr2_rd && seen;

    AST_ARM_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seen) |-> $past(sr1_rd)); // R7
endmodule

// File: rtl/i2cas_flag_bank.sv
// Holds the event and mode flags and forms the event interrupt.
// Assumes set pulses come from the phase FSM and clears from the tracker.
module i2cas_flag_bank (
    input  logic clk,
    input  logic rst_n,
    input  logic set_sb,
    input  logic set_add10,
    input  logic set_addr,
    input  logic set_master,
    input  logic clr_master,
    input  logic set_af,
    input  logic wr_ok,
    input  logic rd2_ok,
    input  logic evt_en,
    output logic flag_sb,
    output logic flag_add10,
    output logic flag_addr,
    output logic flag_master,
    output logic flag_af,
    output logic any_pending,
    output logic evt_irq
);
    // Start-sent: set by the condition, cleared by an armed data write.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_sb <= 1'b0;
        else if (set_sb)     flag_sb <= 1'b1;
        else if (wr_ok)      flag_sb <= 1'b0;
    end

    // Header-sent: set by an acknowledged header, cleared by an armed write.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_add10 <= 1'b0;
        else if (set_add10)  flag_add10 <= 1'b1;
        else if (wr_ok)      flag_add10 <= 1'b0;
    end

    // Address-sent: set by the final acknowledged byte, cleared by an armed status-2 read.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_addr <= 1'b0;
        else if (set_addr)   flag_addr <= 1'b1;
        else if (rd2_ok)     flag_addr <= 1'b0;
    end

    // Master mode: entered with the condition, left on an address NACK.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_master <= 1'b0;
        else if (set_master) flag_master <= 1'b1;
        else if (clr_master) flag_master <= 1'b0;
    end

    // Acknowledge failure: set on NACK, cleared by the next Start.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_af <= 1'b0;
        else if (set_af)     flag_af <= 1'b1;
        else if (set_sb)     flag_af <= 1'b0;
    end

    assign any_pending = flag_sb | flag_add10 | flag_addr;
    assign evt_irq     = evt_en & any_pending;

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_sb, flag_add10, flag_addr})); // R4
    AST_AF_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_af) |-> !flag_master); // R9
endmodule

// File: rtl/i2cas_phase_fsm.sv
// Sequences Start/repeated Start, header and address bytes.
// Assumes the shifter holds cond_done/sh_done for one cycle per request and
// drops a request once it sees the matching done pulse.
module i2cas_phase_fsm
    import i2cas_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              bus_busy,
    input  logic              byte_active,
    input  logic              addr10_mode,
    input  logic [BYTE_W-1:0] dr_wdata,
    input  logic              wr_ok,
    input  logic              rd2_ok,
    input  logic              cond_done,
    input  logic              sh_done,
    input  logic              sh_nack,
    output logic              cond_req,
    output logic              byte_req,
    output logic [BYTE_W-1:0] sh_byte,
    output logic              set_sb,
    output logic              set_add10,
    output logic              set_addr,
    output logic              set_master,
    output logic              clr_master,
    output logic              set_af
);
    phase_t st, st_nx;
    logic   start_pend;
    logic   enter_cond;
    logic   in_send;

    assign enter_cond = start_pend &&
                        (((st == ST_IDLE) && !bus_busy) ||
                         ((st == ST_DATA) && !byte_active));
    assign in_send    = (st == ST_SEND_HDR) || (st == ST_SEND_ADDR);

    // Latch a start request until the condition can be issued.
    always_ff @(posedge clk) begin
        if (!rst_n)          start_pend <= 1'b0;
        else if (enter_cond) start_pend <= 1'b0;
        else if (start_req)  start_pend <= 1'b1;
    end

    // Next-phase selection.
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:      if (enter_cond) st_nx = ST_COND;
            ST_COND:      if (cond_done)  st_nx = ST_WAIT_SB;
            ST_WAIT_SB:   if (wr_ok)      st_nx = addr10_mode ? ST_SEND_HDR : ST_SEND_ADDR;
            ST_SEND_HDR:  if (sh_done)    st_nx = sh_nack ? ST_IDLE : ST_WAIT_HDR;
            ST_WAIT_HDR:  if (wr_ok)      st_nx = ST_SEND_ADDR;
            ST_SEND_ADDR: if (sh_done)    st_nx = sh_nack ? ST_IDLE : ST_WAIT_ADDR;
            ST_WAIT_ADDR: if (rd2_ok)     st_nx = ST_DATA;
            ST_DATA:      if (enter_cond) st_nx = ST_COND;
            default:                      st_nx = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Capture the address byte from the armed data write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_byte <= '0;
        else if (wr_ok && ((st == ST_WAIT_SB) || (st == ST_WAIT_HDR)))
            sh_byte <= dr_wdata;
    end

    assign cond_req   = (st == ST_COND);
    assign byte_req   = in_send;
    assign set_sb     = (st == ST_COND) && cond_done;
    assign set_master = set_sb;
    assign set_add10  = (st == ST_SEND_HDR) && sh_done && !sh_nack;
    assign set_addr   = (st == ST_SEND_ADDR) && sh_done && !sh_nack;
    assign set_af     = in_send && sh_done && sh_nack;
    assign clr_master = set_af;

    AST_START_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cond_req) && ($past(st) == ST_IDLE)) |-> !$past(bus_busy)); // R1
    AST_RESTART_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cond_req) && ($past(st) == ST_DATA)) |-> !$past(byte_active)); // R2
    AST_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && $past(byte_req)) |-> $stable(sh_byte)); // R5
endmodule

// File: rtl/i2c_addr_sequencer.sv
// Top of the I2C master start/address sequencer: phase FSM, flag bank and
// software access-order tracker. Assumes register strobes are one-cycle pulses.
module i2c_addr_sequencer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              bus_busy,
    input  logic              byte_active,
    input  logic              addr10_mode,
    input  logic              evt_en,
    input  logic              dr_wr,
    input  logic [BYTE_W-1:0] dr_wdata,
    input  logic              sr1_rd,
    input  logic              sr2_rd,
    output logic              cond_req,
    input  logic              cond_done,
    output logic              byte_req,
    output logic [BYTE_W-1:0] sh_byte,
    input  logic              sh_done,
    input  logic              sh_nack,
    output logic              flag_sb,
    output logic              flag_add10,
    output logic              flag_addr,
    output logic              flag_master,
    output logic              flag_af,
    output logic              evt_irq
);
    logic wr_ok, rd2_ok, any_pending;
    logic set_sb, set_add10, set_addr, set_master, clr_master, set_af;

    i2cas_access_tracker u_trk (
        .clk(clk), .rst_n(rst_n), .sr1_rd(sr1_rd), .sr2_rd(sr2_rd),
        .dr_wr(dr_wr), .any_pending(any_pending), .wr_ok(wr_ok), .rd2_ok(rd2_ok)
    );

    i2cas_phase_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .bus_busy(bus_busy),
        .byte_active(byte_active), .addr10_mode(addr10_mode), .dr_wdata(dr_wdata),
        .wr_ok(wr_ok), .rd2_ok(rd2_ok), .cond_done(cond_done), .sh_done(sh_done),
        .sh_nack(sh_nack), .cond_req(cond_req), .byte_req(byte_req), .sh_byte(sh_byte),
        .set_sb(set_sb), .set_add10(set_add10), .set_addr(set_addr),
        .set_master(set_master), .clr_master(clr_master), .set_af(set_af)
    );

    i2cas_flag_bank u_flags (
        .clk(clk), .rst_n(rst_n), .set_sb(set_sb), .set_add10(set_add10),
        .set_addr(set_addr), .set_master(set_master), .clr_master(clr_master),
        .set_af(set_af), .wr_ok(wr_ok), .rd2_ok(rd2_ok), .evt_en(evt_en),
        .flag_sb(flag_sb), .flag_add10(flag_add10), .flag_addr(flag_addr),
        .flag_master(flag_master), .flag_af(flag_af), .any_pending(any_pending),
        .evt_irq(evt_irq)
    );

    AST_SB_AFTER_COND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_sb) |-> ($past(cond_done) && $past(cond_req))); // R3
    AST_SB_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_sb) |-> $past(dr_wr)); // R8
    AST_ADDR_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_addr) |-> ($past(sh_done) && !$past(sh_nack))); // R5
    AST_HDR_IN_10BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_add10) |-> $past(addr10_mode) || $past(flag_sb, 2) == 1'b0); // R6
    AST_ADDR_CLEAR_BY_SR2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_addr) |-> $past(sr2_rd)); // R7
endmodule

// File: tb/tb_i2c_addr_sequencer.sv
module tb_i2c_addr_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 0, bus_busy = 0, byte_active = 0, addr10_mode = 0, evt_en = 0;
    logic dr_wr = 0, sr1_rd = 0, sr2_rd = 0;
    logic [7:0] dr_wdata = '0;
    logic cond_req, byte_req, cond_done = 0, sh_done = 0, sh_nack = 0;
    logic [7:0] sh_byte;
    logic flag_sb, flag_add10, flag_addr, flag_master, flag_af, evt_irq;

    int checks = 0, fails = 0;
    bit nack_next = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    i2c_addr_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .bus_busy(bus_busy),
        .byte_active(byte_active), .addr10_mode(addr10_mode), .evt_en(evt_en),
        .dr_wr(dr_wr), .dr_wdata(dr_wdata), .sr1_rd(sr1_rd), .sr2_rd(sr2_rd),
        .cond_req(cond_req), .cond_done(cond_done), .byte_req(byte_req),
        .sh_byte(sh_byte), .sh_done(sh_done), .sh_nack(sh_nack),
        .flag_sb(flag_sb), .flag_add10(flag_add10), .flag_addr(flag_addr),
        .flag_master(flag_master), .flag_af(flag_af), .evt_irq(evt_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit flag_of(input int sel);
        case (sel)
            0: return flag_sb;
            1: return flag_add10;
            2: return flag_addr;
            default: return flag_af;
        endcase
    endfunction

    task automatic wait_flag(input int sel, input string req);
        bit got = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (flag_of(sel)) begin got = 1; break; end
        end
        chk(got, req, int'(got), 1);
    endtask

    task automatic pulse_start();
        start_req = 1; @(negedge clk); start_req = 0;
    endtask
    task automatic read_sr1();
        sr1_rd = 1; @(negedge clk); sr1_rd = 0;
    endtask
    task automatic read_sr2();
        sr2_rd = 1; @(negedge clk); sr2_rd = 0;
    endtask
    // Driver: queue the byte expected on the shifter, then write it.
    task automatic write_dr(input logic [7:0] b, input bit expect_send);
        if (expect_send) exp_q.push_back(b);
        dr_wdata = b; dr_wr = 1; @(negedge clk); dr_wr = 0;
    endtask

    // Shifter model and monitor: answers requests, compares sent bytes.
    initial begin
        forever begin
            @(negedge clk);
            if (cond_req) begin
                repeat (2) @(negedge clk);
                cond_done = 1; @(negedge clk); cond_done = 0;
            end else if (byte_req) begin
                if (exp_q.size() == 0)
                    chk(0, "R8 unexpected byte", int'(sh_byte), 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(sh_byte == e, "R5 sent byte", int'(sh_byte), int'(e));
                end
                repeat (2) @(negedge clk);
                sh_nack = nack_next; sh_done = 1;
                @(negedge clk);
                sh_done = 0; sh_nack = 0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R4: reset state
        chk({flag_sb, flag_add10, flag_addr, flag_master, flag_af, evt_irq} == 0,
            "R4 reset flags", {flag_sb, flag_add10, flag_addr, flag_master, flag_af, evt_irq}, 0);

        // R1: start held off while the bus is busy
        evt_en = 1; bus_busy = 1;
        pulse_start();
        repeat (6) @(negedge clk);
        chk(cond_req == 0 && flag_master == 0, "R1 held while busy", {cond_req, flag_master}, 0);
        bus_busy = 0;
        wait_flag(0, "R3 start-sent set");
        chk(flag_master == 1, "R1 master with start", flag_master, 1);
        chk(evt_irq == 1, "R4 irq on start-sent", evt_irq, 1);

        // R8: write without status-1 read is ignored
        write_dr(8'h5A, 0);
        repeat (6) @(negedge clk);
        chk(flag_sb == 1 && byte_req == 0, "R8 unarmed write ignored", {flag_sb, byte_req}, 2);

        // R5: 7-bit address
        read_sr1();
        write_dr(8'hA4, 1);
        chk(flag_sb == 0, "R8 start-sent cleared", flag_sb, 0);
        wait_flag(2, "R5 address-sent set");
        chk(flag_add10 == 0, "R5 no header flag", flag_add10, 0);
        chk(evt_irq == 1, "R4 irq on address-sent", evt_irq, 1);

        // R7: clearing order of address-sent
        read_sr2();
        repeat (2) @(negedge clk);
        chk(flag_addr == 1, "R7 lone status-2 read", flag_addr, 1);
        read_sr1();
        read_sr2();
        chk(flag_addr == 0 && evt_irq == 0, "R7 cleared by read pair", {flag_addr, evt_irq}, 0);
        chk(flag_master == 1, "R1 master kept", flag_master, 1);

        // R2: repeated start waits for the data byte
        byte_active = 1;
        pulse_start();
        repeat (6) @(negedge clk);
        chk(cond_req == 0, "R2 restart held during byte", cond_req, 0);
        byte_active = 0;
        wait_flag(0, "R2 restart start-sent");

        // R6: 10-bit address
        addr10_mode = 1;
        read_sr1();
        write_dr(8'hF2, 1);
        wait_flag(1, "R6 header-sent set");
        chk(flag_addr == 0 && flag_sb == 0, "R6 only header flag", {flag_sb, flag_addr}, 0);
        evt_en = 0;
        @(negedge clk);
        chk(evt_irq == 0, "R4 irq gated by enable", evt_irq, 0);
        evt_en = 1;
        @(negedge clk);
        chk(evt_irq == 1, "R4 irq on header-sent", evt_irq, 1);
        read_sr1();
        write_dr(8'h3C, 1);
        chk(flag_add10 == 0, "R6 header flag cleared", flag_add10, 0);
        wait_flag(2, "R6 address-sent after second byte");
        read_sr1();
        read_sr2();

        // R9: NACK on an address byte
        addr10_mode = 0;
        pulse_start();
        wait_flag(0, "R9 start before nack");
        nack_next = 1;
        read_sr1();
        write_dr(8'h91, 1);
        wait_flag(3, "R9 ack-failure set");
        nack_next = 0;
        chk(flag_master == 0 && flag_addr == 0, "R9 master dropped", {flag_master, flag_addr}, 0);
        repeat (4) @(negedge clk);
        chk(byte_req == 0 && cond_req == 0, "R9 idle after nack", {byte_req, cond_req}, 0);
        pulse_start();
        wait_flag(0, "R9 start after nack");
        chk(flag_af == 0 && flag_master == 1, "R9 ack-failure cleared", {flag_af, flag_master}, 1);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all bytes sent", exp_q.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule